// File: doc/BRIEF.md
# SAR Conversion Timing Sequencer

This block generates every timing strobe that a 12-bit successive-approximation converter needs around one conversion. A single-cycle convert-start pulse launches a sequence built from two units of time. The first is the fast clock cycle. The second is the SAR period, which is a programmable multiple of the fast clock. Each phase of the sequence is bracketed by single fast-clock sync cycles.

The sequencer does not contain the comparator or the DAC. It drives the code under test on `trial_o` and pulses one bit of `bit_strobe_o` when it samples `cmp_i`. Bits are resolved MSB first. The finished code is published on `result_o`, and `done_o` pulses when the code is ready.

Two tracking arrangements are available:
- **Pre-tracking:** the analog input is tracked while the block is idle, so conversion follows the start immediately.
- **Post-tracking:** a tracking window of programmable length is inserted after the start.

Top module: `sar_conv_seq`

## Requirements
- R1: After reset `busy_o`, `done_o` and `bit_strobe_o` are 0 and `result_o` is 0.
- R2: In pre-tracking mode (`post_track_i`=0 at start), the accepted start is followed by one sync cycle, then 13 SAR periods S1..S13, then one sync cycle. `busy_o` stays high throughout and `track_o` stays low throughout.
- R3: In post-tracking mode (`post_track_i`=1 at start), the sequence is: one sync cycle, then a tracking window with `track_o` high, then one sync cycle, then the 13-period conversion, then one sync cycle.
- R4: The tracking window lasts 2, 4, 8 or 16 SAR periods for `track_code_i` values 0, 1, 2 and 3.
- R5: One SAR period is `div_i`+1 fast clock cycles, where `div_i` is a 5-bit value.
- R6: During S1..S12, `trial_o` shows the decided upper bits with the bit under test set. In the last fast cycle of S_n, exactly bit 12-n of `bit_strobe_o` pulses, so bit 11 (MSB) pulses in S1. No strobe occurs in S13.
- R7: At each strobe, `cmp_i`=1 keeps the tested bit and `cmp_i`=0 clears it. With `cmp_i` = (input >= `trial_o`), `result_o` equals the input code.
- R8: `done_o` pulses for one cycle, in the cycle after the final sync cycle. `result_o` takes the new code in that same cycle and holds it until the next `done_o`.
- R9: A start that arrives while `busy_o` is high is ignored. A start in the `done_o` cycle is accepted.
- R10: `busy_o` rises in the cycle after an accepted start and falls in the `done_o` cycle.
- R11: While idle, `track_o` follows the mode input. It is high when `post_track_i`=0 and low when `post_track_i`=1.
- R12: Mode, tracking code and divider are captured with the start. Changes to them during a conversion have no effect on its timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Convert-start request |
| post_track_i | input | 1 | 1 selects post-tracking, 0 selects pre-tracking |
| track_code_i | input | 2 | Tracking window length code |
| div_i | input | 5 | SAR period minus one, in fast cycles |
| cmp_i | input | 1 | Comparator decision for `trial_o` |
| track_o | output | 1 | Track enable |
| busy_o | output | 1 | Conversion sequence in progress |
| bit_strobe_o | output | 12 | One-hot bit decision strobe |
| trial_o | output | 12 | Code presented to the DAC |
| result_o | output | 12 | Last completed result |
| done_o | output | 1 | End-of-conversion pulse |

## Verification
The bench uses the extreme divider values 0 and 31 and all four tracking codes, because a window or period that is off by one would shift every following strobe by whole cycles. It holds start high across a whole conversion: a design that re-arms early would restart mid-sequence, and one that refuses the start in the `done_o` cycle would drop a back-to-back request. It also alters the mode, code and divider while a conversion is running, which exposes a design that reads the live inputs. Input codes 0, full scale and mixed patterns catch a wrong bit order or an inverted keep decision in the result.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SYNC_A = 3'd1,
    PH_TRACK  = 3'd2,
    PH_SYNC_M = 3'd3,
    PH_CONV   = 3'd4,
    PH_SYNC_B = 3'd5
  } phase_e;

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/sar_clk_div.sv
module sar_clk_div #(
  parameter int unsigned DIV_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cnt_q <= '0;
    else if (!run_i || cnt_q == div_i)    cnt_q <= '0;
    else                                  cnt_q <= cnt_q + 1'b1;
  end

  // back-to-back ticks only allowed for a one-cycle period
  p_tick_spacing_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && div_i != '0 && run_i) |=> !tick_o);

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && $stable(div_i)) |-> (cnt_q <= div_i));
endmodule

// File: rtl/sar_phase_fsm.sv
module sar_phase_fsm
  import sar_seq_pkg::*;
#(
  parameter int unsigned N_BITS  = 12,
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned TCODE_W = 2,
  parameter int unsigned SP_W    = 5
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               post_i,
  input  logic [TCODE_W-1:0] tcode_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               tick_i,
  output phase_e             phase_o,
  output logic [SP_W-1:0]    sp_o,
  output logic [DIV_W-1:0]   div_q_o,
  output logic               done_o,
  output logic               busy_o
);
  localparam logic [SP_W-1:0] CONV_LAST = SP_W'(N_BITS);

  phase_e             phase_q;
  logic [SP_W-1:0]    sp_q;
  logic [DIV_W-1:0]   div_q;
  logic               post_q;
  logic [TCODE_W-1:0] tcode_q;
  logic               done_q;
  logic [SP_W-1:0]    trk_last;

  assign trk_last = (SP_W'(2) << tcode_q) - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      sp_q    <= '0;
      div_q   <= '0;
      post_q  <= 1'b0;
      tcode_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (phase_q == PH_SYNC_B);
      unique case (phase_q)
        PH_IDLE: if (start_i) begin
          phase_q <= PH_SYNC_A;
          div_q   <= div_i;
          post_q  <= post_i;
          tcode_q <= tcode_i;
        end
        PH_SYNC_A: begin
          sp_q    <= '0;
          phase_q <= post_q ? PH_TRACK : PH_CONV;
        end
        PH_TRACK: if (tick_i) begin
          if (sp_q == trk_last) begin
            sp_q    <= '0;
            phase_q <= PH_SYNC_M;
          end else sp_q <= sp_q + 1'b1;
        end
        PH_SYNC_M: begin
          sp_q    <= '0;
          phase_q <= PH_CONV;
        end
        PH_CONV: if (tick_i) begin
          if (sp_q == CONV_LAST) phase_q <= PH_SYNC_B;
          else                   sp_q    <= sp_q + 1'b1;
        end
        PH_SYNC_B: phase_q <= PH_IDLE;
        default:   phase_q <= PH_IDLE;
      endcase
    end
  end

  assign phase_o = phase_q;
  assign sp_o    = sp_q;
  assign div_q_o = div_q;
  assign done_o  = done_q;
  assign busy_o  = (phase_q != PH_IDLE);

  p_start_ignored_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && phase_q != PH_SYNC_B) |=> busy_o);

  p_cfg_hold_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(div_q) && $stable(post_q) && $stable(tcode_q)));

  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_done_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: rtl/sar_bit_reg.sv
module sar_bit_reg #(
  parameter int unsigned N_BITS = 12,
  parameter int unsigned SP_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              conv_i,
  input  logic              load_i,
  input  logic [SP_W-1:0]   sp_i,
  input  logic              tick_i,
  input  logic              cmp_i,
  output logic [N_BITS-1:0] strobe_o,
  output logic [N_BITS-1:0] trial_o,
  output logic [N_BITS-1:0] result_o
);
  logic [N_BITS-1:0] sel;
  logic [N_BITS-1:0] sar_q;
  logic [N_BITS-1:0] res_q;

  // bit i is under test in SAR period N_BITS-1-i (MSB first)
  for (genvar i = 0; i < N_BITS; i++) begin : g_sel
    assign sel[i] = conv_i && (sp_i == SP_W'(N_BITS - 1 - i));
  end

  assign strobe_o = tick_i ? sel : '0;
  assign trial_o  = sar_q | sel;
  assign result_o = res_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sar_q <= '0;
      res_q <= '0;
    end else begin
      if (clear_i)       sar_q <= '0;
      else if (|strobe_o) sar_q <= (sar_q & ~strobe_o) | (cmp_i ? strobe_o : '0);
      if (load_i)        res_q <= sar_q;
    end
  end

  p_strobe_onehot_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(strobe_o));

  p_result_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(result_o));

  p_keep_bit_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|strobe_o) && cmp_i) |=> ((sar_q & $past(strobe_o)) != '0));
endmodule

// File: rtl/sar_conv_seq.sv
module sar_conv_seq
  import sar_seq_pkg::*;
#(
  parameter int unsigned N_BITS  = 12,
  parameter int unsigned DIV_W   = 5,
  parameter int unsigned TCODE_W = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               post_track_i,
  input  logic [TCODE_W-1:0] track_code_i,
  input  logic [DIV_W-1:0]   div_i,
  input  logic               cmp_i,
  output logic               track_o,
  output logic               busy_o,
  output logic [N_BITS-1:0]  bit_strobe_o,
  output logic [N_BITS-1:0]  trial_o,
  output logic [N_BITS-1:0]  result_o,
  output logic               done_o
);
  localparam int unsigned MAX_TRK = 2 << ((1 << TCODE_W) - 1);
  localparam int unsigned SP_W    = $clog2(max_u(MAX_TRK, N_BITS + 1) + 1);

  phase_e           phase;
  logic [SP_W-1:0]  sp;
  logic [DIV_W-1:0] div_q;
  logic             tick;
  logic             run;

  assign run     = (phase == PH_TRACK) || (phase == PH_CONV);
  assign track_o = ((phase == PH_IDLE) && !post_track_i) || (phase == PH_TRACK);

  sar_phase_fsm #(
    .N_BITS(N_BITS), .DIV_W(DIV_W), .TCODE_W(TCODE_W), .SP_W(SP_W)
  ) u_fsm (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .post_i  (post_track_i),
    .tcode_i (track_code_i),
    .div_i   (div_i),
    .tick_i  (tick),
    .phase_o (phase),
    .sp_o    (sp),
    .div_q_o (div_q),
    .done_o  (done_o),
    .busy_o  (busy_o)
  );

  sar_clk_div #(.DIV_W(DIV_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .div_i  (div_q),
    .tick_o (tick)
  );

  sar_bit_reg #(.N_BITS(N_BITS), .SP_W(SP_W)) u_sar (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (phase == PH_SYNC_A),
    .conv_i   (phase == PH_CONV),
    .load_i   (phase == PH_SYNC_B),
    .sp_i     (sp),
    .tick_i   (tick),
    .cmp_i    (cmp_i),
    .strobe_o (bit_strobe_o),
    .trial_o  (trial_o),
    .result_o (result_o)
  );

  p_strobe_busy_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|bit_strobe_o) |-> (busy_o && !track_o));

  p_track_post_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && track_o) |=> (busy_o && !done_o));
endmodule

// File: tb/sar_conv_seq_tb.sv
module sar_conv_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        post = 1'b0;
  logic [1:0]  tcode = '0;
  logic [4:0]  div = '0;
  logic        cmp;
  logic        track, busy, done;
  logic [11:0] strobe, trial, result;

  int unsigned vin_cur = 0;
  int unsigned exp_res = 0;
  int unsigned n_vec = 0;
  int unsigned n_bad = 0;
  int unsigned n_cyc = 0;
  string       req = "R1";

  typedef struct {
    bit busy;
    int trk;   // 0 low, 1 high, 2 follow idle mode
    int sidx;  // bit under test strobed this cycle, -1 none
    bit done;
    int unsigned vin;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;
  assign cmp = (vin_cur >= 32'(trial));

  sar_conv_seq u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .post_track_i(post),
    .track_code_i(tcode), .div_i(div), .cmp_i(cmp), .track_o(track),
    .busy_o(busy), .bit_strobe_o(strobe), .trial_o(trial),
    .result_o(result), .done_o(done)
  );

  task automatic chk(input string tag, input int unsigned act, input int unsigned expv);
    n_vec++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s/%s at cycle %0d: actual %0h expected %0h", req, tag, n_cyc, act, expv);
    end
  endtask

  function automatic exp_t mk(bit b, int t, int s, bit d, int unsigned v);
    exp_t e;
    e.busy = b; e.trk = t; e.sidx = s; e.done = d; e.vin = v;
    return e;
  endfunction

  task automatic push_seq(bit p, int tc, int dv, int unsigned v);
    int d = dv + 1;
    q.push_back(mk(1, 0, -1, 0, v));
    if (p) begin
      for (int i = 0; i < (2 << tc) * d; i++) q.push_back(mk(1, 1, -1, 0, v));
      q.push_back(mk(1, 0, -1, 0, v));
    end
    for (int s = 0; s < 13; s++)
      for (int c = 0; c < d; c++)
        q.push_back(mk(1, 0, (s < 12 && c == d - 1) ? 11 - s : -1, 0, v));
    q.push_back(mk(1, 0, -1, 0, v));
    q.push_back(mk(0, 2, -1, 1, v));
  endtask

  task automatic cyc(bit st, bit p, int tc, int dv, int unsigned v);
    exp_t e;
    @(negedge clk);
    if (q.size() != 0) e = q.pop_front();
    else e = mk(0, 2, -1, 0, 0);
    if (e.done) exp_res = e.vin;
    chk("busy R10", busy, e.busy);
    chk("done R8", done, e.done);
    chk("track R3 R11", track, (e.trk == 2) ? 32'(!post) : e.trk);
    chk("strobe R6", strobe, (e.sidx >= 0) ? (1 << e.sidx) : 0);
    if (e.sidx >= 0)
      chk("trial R6", trial, (e.vin & ~((1 << (e.sidx + 1)) - 1) & 12'hfff) | (1 << e.sidx));
    chk("result R7", result, exp_res);
    start = st; post = p; tcode = 2'(tc); div = 5'(dv);
    if (st && q.size() == 0) begin
      push_seq(p, tc, dv, v);
      vin_cur = v;
    end
  endtask

  task automatic conv(bit p, int tc, int dv, int unsigned v, bit wiggle);
    cyc(1, p, tc, dv, v);
    while (q.size() != 0) begin
      if (wiggle) cyc(0, ~p, (tc + n_cyc) % 4, (dv + 7 * n_cyc) % 32, v);
      else        cyc(0, p, tc, dv, v);
    end
    cyc(0, p, tc, dv, v);
  endtask

  always @(posedge clk) begin
    n_cyc++;
    if (n_cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog %s: actual timeout expected completion", req);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk("busy R1", busy, 0);
    chk("done R1", done, 0);
    chk("strobe R1", strobe, 0);
    chk("result R1", result, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc(0, i[0], 0, 0, 0);

    req = "R2";  conv(0, 0, 0, 12'ha5c, 0);
    req = "R5";  conv(0, 0, 3, 12'hfff, 0);
    req = "R5";  conv(1, 0, 31, 12'h3c1, 0);
    for (int tc = 0; tc < 4; tc++) begin
      req = "R4"; conv(1, tc, 1, 12'h555 + tc * 300, 0);
    end
    req = "R7";  conv(0, 1, 2, 0, 0);
    req = "R7";  conv(1, 2, 0, 12'h800, 0);

    // R9: start held high; only the done cycle may re-arm
    req = "R9";
    cyc(1, 1, 0, 2, 12'h0f0);
    while (q.size() > 1) cyc(1, 1, 0, 2, 12'h0f0);
    cyc(1, 0, 1, 1, 12'h7ab);  // done cycle: accepted
    while (q.size() != 0) cyc(0, 0, 1, 1, 12'h7ab);
    cyc(0, 0, 0, 0, 0);

    // R12: config inputs change mid-conversion
    req = "R12"; conv(1, 1, 4, 12'h9e3, 1);
    req = "R12"; conv(0, 3, 5, 12'h123, 1);
    req = "R11";
    for (int i = 0; i < 6; i++) cyc(0, i[1], 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule